// File: doc/BRIEF.md
# Selectable-Line Pin Interrupt Front End

This block turns eight general-purpose input lines into eight interrupt requests for a processor's interrupt controller. Each line is first brought into the clock domain by a short synchroniser chain. It is then judged either on its edges or on its level. In edge operation a rising edge and a falling edge each leave a sticky capture bit, and each has its own enable. A line whose two enables are both on fires on either edge. In level operation one enable gates the line and a second bit picks the active polarity. The request then follows the pin for as long as the pin stays active.

Software sets everything up through a zero-wait 32-bit register port in the APB style. The port has no back-pressure: a write takes effect on the clock edge at the end of its access phase, and read data are valid throughout any selected read cycle. Each enable has three views: a plain read/write register, a write-one-to-set alias and a write-one-to-clear alias. Software never needs a read-modify-write to change a single line. Edge requests are acknowledged by writing ones to the status word.

Top module: `pin_irq_front`

## Requirements
- R1: After reset every register reads zero and every `irq_o` bit is low. Every line starts in edge operation with both enables off.
- R2: Register map at byte offsets: 0x00 mode (bit 1 = level, 0 = edge), 0x04 rise/level enable, 0x10 fall/polarity enable, 0x1C rising-captured, 0x20 falling-captured, 0x24 status. Bits 7:0 map to lines 7:0. Bits 31:8 are ignored on write and read as zero.
- R3: A write to 0x08 ORs its ones into the rise enable, and a write to 0x0C clears only the rise-enable bits written as one. Offsets 0x14 and 0x18 do the same for the fall enable. All four aliases read as zero.
- R4: In edge operation a rising input edge sets bit i of 0x1C. With rise enable i on, it drives `irq_o[i]` high.
- R5: In edge operation a falling input edge sets bit i of 0x20. With fall enable i on, it drives `irq_o[i]` high.
- R6: With both enables on, an edge line requests on either edge.
- R7: A captured edge whose enable is off does not raise `irq_o`. The capture bit is still set.
- R8: Writing 1 to bit i of 0x24 clears both capture bits of line i and drops an edge request. Bits written as 0 leave the other lines' requests in place.
- R9: Writing 1 to bit i of 0x1C or of 0x20 clears that capture bit alone.
- R10: In level operation `irq_o[i]` equals the rise enable ANDed with the synchronised pin. The pin is taken as is when fall enable i is 1 and inverted when it is 0. Writing the status word does not clear it.
- R11: When a new edge capture and a clearing write to the same bit fall on one clock edge, the capture wins.
- R12: An input change made before clock edge k shows on `irq_o` after edge k+2 for an edge line and after edge k+1 for a level line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Register port select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 6 | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while selected |
| pin_i | input | 8 | Asynchronous input lines |
| irq_o | output | 8 | One request per line |

## Verification
Two events can land on the same clock edge: a freshly synchronised edge setting a capture bit, and a status write clearing that bit. The bench changes a pin and then times a status write so that its access phase ends on exactly the edge where the capture registers. It expects the request and the capture bit to survive. A second case acknowledges one line while another line is pending, and checks that the pending request is left alone.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int unsigned LINES = 8;
  localparam int unsigned DW    = 32;
  localparam int unsigned AW    = 6;

  typedef enum logic [AW-1:0] {
    OFS_MODE = 6'h00,
    OFS_REN  = 6'h04,
    OFS_RSET = 6'h08,
    OFS_RCLR = 6'h0C,
    OFS_FEN  = 6'h10,
    OFS_FSET = 6'h14,
    OFS_FCLR = 6'h18,
    OFS_RCAP = 6'h1C,
    OFS_FCAP = 6'h20,
    OFS_STAT = 6'h24
  } reg_ofs_e;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int unsigned N      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [STAGES-1:0][N-1:0] stg_q;
  logic [N-1:0]             prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q  <= '0;
      prev_q <= '0;
    end else begin
      stg_q[0] <= pin_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign lvl_o  = stg_q[STAGES-1];
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [N-1:0]  wr_data,
  input  logic [N-1:0]  rise_i,
  input  logic [N-1:0]  fall_i,
  output logic [N-1:0]  mode_q,
  output logic [N-1:0]  ren_q,
  output logic [N-1:0]  fen_q,
  output logic [N-1:0]  rcap_q,
  output logic [N-1:0]  fcap_q
);
  logic [N-1:0] mode_d, ren_d, fen_d, rclr, fclr;

  always_comb begin
    mode_d = mode_q;
    ren_d  = ren_q;
    fen_d  = fen_q;
    rclr   = '0;
    fclr   = '0;
    if (wr_en) begin
      case (wr_addr)
        OFS_MODE: mode_d = wr_data;
        OFS_REN:  ren_d  = wr_data;
        OFS_RSET: ren_d  = ren_q | wr_data;
        OFS_RCLR: ren_d  = ren_q & ~wr_data;
        OFS_FEN:  fen_d  = wr_data;
        OFS_FSET: fen_d  = fen_q | wr_data;
        OFS_FCLR: fen_d  = fen_q & ~wr_data;
        OFS_RCAP: rclr   = wr_data;
        OFS_FCAP: fclr   = wr_data;
        OFS_STAT: begin
          rclr = wr_data;
          fclr = wr_data;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ren_q  <= '0;
      fen_q  <= '0;
      rcap_q <= '0;
      fcap_q <= '0;
    end else begin
      mode_q <= mode_d;
      ren_q  <= ren_d;
      fen_q  <= fen_d;
      rcap_q <= (rcap_q & ~rclr) | rise_i;
      fcap_q <= (fcap_q & ~fclr) | fall_i;
    end
  end
endmodule

// File: rtl/pin_irq_eval.sv
module pin_irq_eval #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] mode_i,
  input  logic [N-1:0] ren_i,
  input  logic [N-1:0] fen_i,
  input  logic [N-1:0] rcap_i,
  input  logic [N-1:0] fcap_i,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    logic edge_req, lvl_req;
    assign edge_req  = (rcap_i[i] & ren_i[i]) | (fcap_i[i] & fen_i[i]);
    assign lvl_req   = ren_i[i] & (fen_i[i] ? lvl_i[i] : ~lvl_i[i]);
    assign stat_o[i] = mode_i[i] ? lvl_req : edge_req;
  end
endmodule

// File: rtl/pin_irq_front.sv
module pin_irq_front
  import pin_irq_pkg::*;
#(
  parameter int unsigned N           = LINES,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [DW-1:0] pwdata,
  output logic [DW-1:0] prdata,
  input  logic [N-1:0]  pin_i,
  output logic [N-1:0]  irq_o
);
  logic [N-1:0] lvl, rise, fall;
  logic [N-1:0] mode_q, ren_q, fen_q, rcap_q, fcap_q, stat;
  logic         wr_en;
  logic         unused_hi;

  assign wr_en     = psel & penable & pwrite;
  assign unused_hi = ^pwdata[DW-1:N];

  pin_irq_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  pin_irq_regs #(.N(N)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(paddr),
    .wr_data(pwdata[N-1:0]), .rise_i(rise), .fall_i(fall),
    .mode_q(mode_q), .ren_q(ren_q), .fen_q(fen_q),
    .rcap_q(rcap_q), .fcap_q(fcap_q)
  );

  pin_irq_eval #(.N(N)) u_eval (
    .mode_i(mode_q), .ren_i(ren_q), .fen_i(fen_q),
    .rcap_i(rcap_q), .fcap_i(fcap_q), .lvl_i(lvl), .stat_o(stat)
  );

  assign irq_o = stat;

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (paddr)
        OFS_MODE: prdata[N-1:0] = mode_q;
        OFS_REN:  prdata[N-1:0] = ren_q;
        OFS_FEN:  prdata[N-1:0] = fen_q;
        OFS_RCAP: prdata[N-1:0] = rcap_q;
        OFS_FCAP: prdata[N-1:0] = fcap_q;
        OFS_STAT: prdata[N-1:0] = stat;
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk
  import pin_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          psel,
  input logic          penable,
  input logic          pwrite,
  input logic [AW-1:0] paddr,
  input logic [DW-1:0] pwdata,
  input logic [DW-1:0] prdata,
  input logic [N-1:0]  irq_o,
  input logic [N-1:0]  mode_q,
  input logic [N-1:0]  ren_q,
  input logic [N-1:0]  fen_q,
  input logic [N-1:0]  rcap_q,
  input logic [N-1:0]  rise
);
  logic wr;
  assign wr = psel && penable && pwrite;

  AST_ALIAS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite && (paddr == OFS_RSET || paddr == OFS_RCLR ||
     paddr == OFS_FSET || paddr == OFS_FCLR)) |-> (prdata == '0)); // R3

  AST_SET_ALIAS_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == OFS_RSET) |=> ((ren_q & $past(pwdata[N-1:0])) == $past(pwdata[N-1:0]))); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (psel && !pwrite) |-> (prdata[DW-1:N] == '0)); // R2

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ((($past(irq_o) & ~$past(mode_q)) & ~irq_o) == '0)); // R8

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rcap_q & $past(rise)) == $past(rise))); // R11

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~(ren_q | (fen_q & ~mode_q))) == '0)); // R7
endmodule

bind pin_irq_front pin_irq_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_o(irq_o),
  .mode_q(mode_q), .ren_q(ren_q), .fen_q(fen_q), .rcap_q(rcap_q), .rise(rise)
);

// File: tb/tb_pin_irq_front.sv
module tb_pin_irq_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [7:0]  pin_i = '0;
  logic [7:0]  irq_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pin_irq_front dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_i(pin_i), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // Called at a negedge; the write lands on the second following posedge.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1'b1;
    @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    @(negedge clk); psel = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    for (int a = 0; a <= 'h24; a += 4) begin
      rd(a[5:0], d);
      chk("R1 reg", d, 32'h0);
    end
    chk("R1 irq", {24'h0, irq_o}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_FFA5); rd(6'h00, d); chk("R2 mode", d, 32'hA5);
    wr(6'h04, 32'hFFFF_FF3C); rd(6'h04, d); chk("R2 ren", d, 32'h3C);
    wr(6'h10, 32'h0000_00C3); rd(6'h10, d); chk("R2 fen", d, 32'hC3);
    wr(6'h00, 0); wr(6'h04, 0); wr(6'h10, 0);
  endtask

  task automatic t_alias;
    logic [31:0] d;
    wr(6'h04, 32'h0F); wr(6'h08, 32'h30); rd(6'h04, d); chk("R3 rset", d, 32'h3F);
    wr(6'h0C, 32'h05); rd(6'h04, d); chk("R3 rclr", d, 32'h3A);
    wr(6'h14, 32'h81); wr(6'h18, 32'h01); rd(6'h10, d); chk("R3 fset/fclr", d, 32'h80);
    rd(6'h08, d); chk("R3 alias read", d, 32'h0);
    rd(6'h18, d); chk("R3 alias read", d, 32'h0);
    wr(6'h04, 0); wr(6'h10, 0);
  endtask

  task automatic t_rise_ack;
    logic [31:0] d;
    wr(6'h04, 32'h03);
    pin_i[0] = 1'b1;
    wait_n(2); chk("R12 edge early", {31'h0, irq_o[0]}, 32'h0);
    wait_n(1); chk("R12 edge on time", {31'h0, irq_o[0]}, 32'h1);
    rd(6'h1C, d); chk("R4 rcap", d & 32'h1, 32'h1);
    pin_i[1] = 1'b1; wait_n(4);
    chk("R4 two pending", {24'h0, irq_o}, 32'h03);
    wr(6'h24, 32'h01); wait_n(1);
    chk("R8 partial ack", {24'h0, irq_o}, 32'h02);
    wr(6'h24, 32'h02); wait_n(1);
    chk("R8 ack", {24'h0, irq_o}, 32'h00);
    wr(6'h04, 0);
  endtask

  task automatic t_fall;
    logic [31:0] d;
    wr(6'h10, 32'h04);
    pin_i[2] = 1'b1; wait_n(4);
    chk("R7 disabled rise", {31'h0, irq_o[2]}, 32'h0);
    rd(6'h1C, d); chk("R7 rcap set", d & 32'h4, 32'h4);
    pin_i[2] = 1'b0; wait_n(4);
    chk("R5 fall irq", {31'h0, irq_o[2]}, 32'h1);
    rd(6'h20, d); chk("R5 fcap", d & 32'h4, 32'h4);
    wr(6'h20, 32'h04); wait_n(1);
    chk("R9 fcap clear irq", {31'h0, irq_o[2]}, 32'h0);
    rd(6'h1C, d); chk("R9 rcap kept", d & 32'h4, 32'h4);
    wr(6'h1C, 32'h04); rd(6'h1C, d); chk("R9 rcap clear", d & 32'h4, 32'h0);
    wr(6'h10, 0);
  endtask

  task automatic t_both;
    wr(6'h04, 32'h08); wr(6'h10, 32'h08);
    pin_i[3] = 1'b1; wait_n(4);
    chk("R6 rise", {31'h0, irq_o[3]}, 32'h1);
    wr(6'h24, 32'h08); wait_n(1);
    chk("R6 ack", {31'h0, irq_o[3]}, 32'h0);
    pin_i[3] = 1'b0; wait_n(4);
    chk("R6 fall", {31'h0, irq_o[3]}, 32'h1);
    wr(6'h24, 32'h08); wr(6'h04, 0); wr(6'h10, 0);
  endtask

  task automatic t_level;
    wr(6'h00, 32'h10); wr(6'h04, 32'h10); wr(6'h10, 32'h10);
    wait_n(1); chk("R10 high idle", {31'h0, irq_o[4]}, 32'h0);
    pin_i[4] = 1'b1;
    wait_n(1); chk("R12 level early", {31'h0, irq_o[4]}, 32'h0);
    wait_n(1); chk("R12 level on time", {31'h0, irq_o[4]}, 32'h1);
    wr(6'h24, 32'h10); wait_n(1);
    chk("R10 no clear", {31'h0, irq_o[4]}, 32'h1);
    pin_i[4] = 1'b0; wait_n(3);
    chk("R10 follows", {31'h0, irq_o[4]}, 32'h0);
    wr(6'h18, 32'h10); wait_n(1);
    chk("R10 active low", {31'h0, irq_o[4]}, 32'h1);
    pin_i[4] = 1'b1; wait_n(3);
    chk("R10 low released", {31'h0, irq_o[4]}, 32'h0);
    wr(6'h00, 0); wr(6'h04, 0); wr(6'h1C, 32'hFF); wr(6'h20, 32'hFF);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(6'h04, 32'h20);
    pin_i[5] = 1'b1;
    @(negedge clk);
    wr(6'h24, 32'h20);   // clear lands on the capture edge
    wait_n(1);
    chk("R11 irq kept", {31'h0, irq_o[5]}, 32'h1);
    rd(6'h1C, d); chk("R11 rcap kept", d & 32'h20, 32'h20);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got hang expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_alias();
    t_rise_ack();
    t_fall();
    t_both();
    t_level();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule